// File: doc/BRIEF.md
# Board Status and Display Register File

This block is a bank of memory-mapped control registers for a development board, reached over a plain 32-bit read/write bus with single-cycle commands. It drives an 8-segment LED bar, an eight-character ASCII display and a general-purpose output byte, raises a one-cycle system reset request on a keyed write, and exposes bit-banged two-wire registers whose data-in bit comes from a serial EEPROM line.

Only the low 20 address bits are decoded, so the bank aliases throughout any larger window. The display can be loaded either a whole word at a time (the value is rendered as eight uppercase hex digits) or one character at a time. An address window reserved for a UART that shares the range gets no response from this block. Any other undecoded access reads zero and latches an error flag that only reset clears.

Top module: `board_regs_top`

## Requirements
- R1: Decode uses bus_addr[19:0] only; bits 31..20 have no effect on which register is hit.
- R2: A write to offset 0x408 stores wdata[7:0] on led_bar; a read of 0x408 returns it in bits 7..0 with zeros above.
- R3: A write to offset 0x410 sets all eight display characters to the uppercase hex ASCII rendering of wdata ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46); character i sits at disp_chars[8i+7:8i] and holds nibble wdata[31-4i:28-4i], so character 0 carries the most significant nibble.
- R4: A write to offset 0x418 + 8*i (i = 0..7) replaces only character i with wdata[7:0]; every other character keeps its value.
- R5: After reset every display character is 0x20 (space), led_bar, gpo, the two-wire output, enable and select bits are 0, and bus_err, reset_req and bus_rvalid are 0.
- R6: A write of exactly 0x0000_0042 to offset 0x500 makes reset_req high for the single cycle after the write edge; a write of any other value there leaves it low.
- R7: Offset 0x200 reads as zero; writes to it change no output and set no error.
- R8: A write to 0xB10 drives tw_scl from wdata[1] and tw_sda from wdata[0]; 0xB08 stores wdata[1:0] on tw_oe and 0xB18 stores wdata[0] on tw_sel; each reads back in its low bits.
- R9: A read of 0xB00 returns bit 1 = the stored tw_scl value and bit 0 = eeprom_sda at the edge the read is taken, all other bits zero.
- R10: A write to 0xA00 stores wdata[7:0] on gpo, readable at 0xA00.
- R11: bus_rvalid and bus_rdata appear exactly one cycle after the bus_rd cycle; bus_rdata is zero whenever bus_rvalid is low. The write-only offsets 0x410, 0x418+8*i and 0x500 read as zero without error.
- R12: Reads and writes in the window 0x900..0x9FF produce no bus_rvalid, no error and no change at any output.
- R13: Any other offset reads zero with bus_rvalid, and any access to it sets bus_err, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address |
| bus_wr | input | 1 | Write command for this cycle |
| bus_rd | input | 1 | Read command for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| bus_err | output | 1 | Sticky undecoded-access flag |
| led_bar | output | 8 | LED bar pattern |
| disp_chars | output | 64 | Eight ASCII characters, character i in bits 8i+7..8i |
| reset_req | output | 1 | One-cycle system reset request |
| gpo | output | 8 | General-purpose output byte |
| tw_scl | output | 1 | Two-wire clock level |
| tw_sda | output | 1 | Two-wire data level |
| tw_oe | output | 2 | Two-wire output enables |
| tw_sel | output | 1 | Two-wire bus select |
| eeprom_sda | input | 1 | Data line returned by the EEPROM |

## Verification
The hardest situations to reach are the near misses in decode: an offset inside the character range but off its 8-byte stride, an address whose upper twelve bits differ from the register it aliases, and the soft-reset offset written with a value that is not the key. The random stimulus draws offsets from a list that mixes every register, the UART window, misaligned character offsets and holes, attaches random upper address bits, and biases soft-reset data toward the key so both outcomes occur often; directed steps then confirm the word expansion, single-character replacement and the clearing of the error flag by reset.

// File: rtl/board_regs_pkg.sv
package board_regs_pkg;
  parameter int ADDR_W    = 32;
  parameter int DATA_W    = 32;
  parameter int DEC_W     = 20;
  parameter int NUM_CHARS = 8;
  parameter int CHAR_W    = 8;
  parameter int BYTE_W    = 8;

  localparam int NIB_W    = 4;
  localparam int TW_OE_W  = 2;

  localparam logic [DEC_W-1:0] OFF_SWITCH  = 20'h00200;
  localparam logic [DEC_W-1:0] OFF_LED     = 20'h00408;
  localparam logic [DEC_W-1:0] OFF_WORD    = 20'h00410;
  localparam logic [DEC_W-1:0] OFF_CHAR0   = 20'h00418;
  localparam int               CHAR_STRIDE = 8;
  localparam logic [DEC_W-1:0] OFF_SRST    = 20'h00500;
  localparam logic [DEC_W-1:0] OFF_UART_LO = 20'h00900;
  localparam logic [DEC_W-1:0] OFF_UART_HI = 20'h009FF;
  localparam logic [DEC_W-1:0] OFF_GPO     = 20'h00A00;
  localparam logic [DEC_W-1:0] OFF_TW_IN   = 20'h00B00;
  localparam logic [DEC_W-1:0] OFF_TW_OE   = 20'h00B08;
  localparam logic [DEC_W-1:0] OFF_TW_OUT  = 20'h00B10;
  localparam logic [DEC_W-1:0] OFF_TW_SEL  = 20'h00B18;

  localparam logic [DATA_W-1:0] SRST_KEY   = 32'h0000_0042;
  localparam logic [CHAR_W-1:0] CHAR_SPACE = 8'h20;

  typedef struct packed {
    logic                 sw;
    logic                 led;
    logic                 word;
    logic                 srst;
    logic                 gpo;
    logic                 tw_in;
    logic                 tw_oe;
    logic                 tw_out;
    logic                 tw_sel;
    logic                 uart;
    logic                 known;
    logic [NUM_CHARS-1:0] chr;
  } hit_t;

  function automatic logic [CHAR_W-1:0] nibble_to_ascii(input logic [NIB_W-1:0] n);
    logic [CHAR_W-1:0] wide;
    wide = {{(CHAR_W-NIB_W){1'b0}}, n};
    return (n < 4'd10) ? (8'h30 + wide) : (8'h37 + wide);
  endfunction
endpackage

// File: rtl/board_regs_decode.sv
module board_regs_decode
  import board_regs_pkg::*;
(
  input  logic [DEC_W-1:0] offset,
  output hit_t             hit
);
  always_comb begin
    hit        = '0;
    hit.sw     = (offset == OFF_SWITCH);
    hit.led    = (offset == OFF_LED);
    hit.word   = (offset == OFF_WORD);
    hit.srst   = (offset == OFF_SRST);
    hit.gpo    = (offset == OFF_GPO);
    hit.tw_in  = (offset == OFF_TW_IN);
    hit.tw_oe  = (offset == OFF_TW_OE);
    hit.tw_out = (offset == OFF_TW_OUT);
    hit.tw_sel = (offset == OFF_TW_SEL);
    hit.uart   = (offset >= OFF_UART_LO) && (offset <= OFF_UART_HI);
    for (int i = 0; i < NUM_CHARS; i++) begin
      hit.chr[i] = (offset == OFF_CHAR0 + DEC_W'(i * CHAR_STRIDE));
    end
    hit.known = hit.sw | hit.led | hit.word | hit.srst | hit.gpo | hit.tw_in |
                hit.tw_oe | hit.tw_out | hit.tw_sel | hit.uart | (|hit.chr);
  end
endmodule

// File: rtl/board_regs_display.sv
module board_regs_display
  import board_regs_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        word_we,
  input  logic [NUM_CHARS-1:0]        chr_we,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_CHARS*CHAR_W-1:0] chars
);
  for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
    localparam int NIB_HI = DATA_W - 1 - NIB_W * i;
    logic [CHAR_W-1:0] cur_q;
    logic [CHAR_W-1:0] nxt_d;
    logic              en;

    always_comb begin
      en    = word_we | chr_we[i];
      nxt_d = cur_q;
      if (word_we)        nxt_d = nibble_to_ascii(wdata[NIB_HI -: NIB_W]);
      else if (chr_we[i]) nxt_d = wdata[CHAR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cur_q <= CHAR_SPACE;
      else if (en) cur_q <= nxt_d;
    end

    assign chars[CHAR_W*i +: CHAR_W] = cur_q;
  end
endmodule

// File: rtl/board_regs_top.sv
module board_regs_top
  import board_regs_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_rvalid,
  output logic                        bus_err,
  output logic [BYTE_W-1:0]           led_bar,
  output logic [NUM_CHARS*CHAR_W-1:0] disp_chars,
  output logic                        reset_req,
  output logic [BYTE_W-1:0]           gpo,
  output logic                        tw_scl,
  output logic                        tw_sda,
  output logic [TW_OE_W-1:0]          tw_oe,
  output logic                        tw_sel,
  input  logic                        eeprom_sda
);
  hit_t hit;
  logic unused_addr_hi;
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:DEC_W];

  board_regs_decode u_decode (
    .offset (bus_addr[DEC_W-1:0]),
    .hit    (hit)
  );

  board_regs_display u_display (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_we (bus_wr & hit.word),
    .chr_we  ({NUM_CHARS{bus_wr}} & hit.chr),
    .wdata   (bus_wdata),
    .chars   (disp_chars)
  );

  logic [BYTE_W-1:0]  led_q, gpo_q;
  logic [1:0]         tw_out_q;
  logic [TW_OE_W-1:0] tw_oe_q;
  logic               tw_sel_q, err_q, srst_q, rvalid_q;
  logic [DATA_W-1:0]  rdata_q;

  logic led_en, gpo_en, tw_out_en, tw_oe_en, tw_sel_en;
  logic err_d, srst_d, rvalid_d;
  logic [DATA_W-1:0] rd_val, rdata_d;

  // Next-state logic
  always_comb begin
    led_en    = bus_wr & hit.led;
    gpo_en    = bus_wr & hit.gpo;
    tw_out_en = bus_wr & hit.tw_out;
    tw_oe_en  = bus_wr & hit.tw_oe;
    tw_sel_en = bus_wr & hit.tw_sel;
    srst_d    = bus_wr & hit.srst & (bus_wdata == SRST_KEY);
    err_d     = err_q | ((bus_wr | bus_rd) & ~hit.known);

    rd_val = '0;
    if (hit.led)    rd_val[BYTE_W-1:0]  = led_q;
    if (hit.gpo)    rd_val[BYTE_W-1:0]  = gpo_q;
    if (hit.tw_in)  rd_val[1:0]         = {tw_out_q[1], eeprom_sda};
    if (hit.tw_out) rd_val[1:0]         = tw_out_q;
    if (hit.tw_oe)  rd_val[TW_OE_W-1:0] = tw_oe_q;
    if (hit.tw_sel) rd_val[0]           = tw_sel_q;

    rvalid_d = bus_rd & ~hit.uart;
    rdata_d  = rvalid_d ? rd_val : '0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q    <= '0;
      gpo_q    <= '0;
      tw_out_q <= '0;
      tw_oe_q  <= '0;
      tw_sel_q <= 1'b0;
      err_q    <= 1'b0;
      srst_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (led_en)    led_q    <= bus_wdata[BYTE_W-1:0];
      if (gpo_en)    gpo_q    <= bus_wdata[BYTE_W-1:0];
      if (tw_out_en) tw_out_q <= bus_wdata[1:0];
      if (tw_oe_en)  tw_oe_q  <= bus_wdata[TW_OE_W-1:0];
      if (tw_sel_en) tw_sel_q <= bus_wdata[0];
      err_q    <= err_d;
      srst_q   <= srst_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign bus_err    = err_q;
  assign led_bar    = led_q;
  assign gpo        = gpo_q;
  assign reset_req  = srst_q;
  assign tw_scl     = tw_out_q[1];
  assign tw_sda     = tw_out_q[0];
  assign tw_oe      = tw_oe_q;
  assign tw_sel     = tw_sel_q;
endmodule

// File: rtl/board_regs_chk.sv
module board_regs_chk
  import board_regs_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic                        bus_rvalid,
  input logic                        bus_err,
  input logic [BYTE_W-1:0]           led_bar,
  input logic [NUM_CHARS*CHAR_W-1:0] disp_chars,
  input logic                        reset_req,
  input logic                        tw_scl,
  input logic                        tw_sda
);
  logic [DEC_W-1:0] off;
  assign off = bus_addr[DEC_W-1:0];

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err);

  // R11
  rvalid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));

  // R11
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> (bus_rdata == '0));

  // R12
  uart_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && off >= OFF_UART_LO && off <= OFF_UART_HI) |=> !bus_rvalid);

  // R6
  reset_req_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(bus_wr && off == OFF_SRST && bus_wdata == SRST_KEY));

  // R2
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(led_bar));

  // R3
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(disp_chars));

  // R8
  tw_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == OFF_TW_OUT) |=> (tw_scl == $past(bus_wdata[1]) && tw_sda == $past(bus_wdata[0])));
endmodule

bind board_regs_top board_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .bus_err    (bus_err),
  .led_bar    (led_bar),
  .disp_chars (disp_chars),
  .reset_req  (reset_req),
  .tw_scl     (tw_scl),
  .tw_sda     (tw_sda)
);

// File: tb/board_regs_top_tb.sv
module board_regs_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err, reset_req, tw_scl, tw_sda, tw_sel;
  logic [7:0]  led_bar, gpo;
  logic [63:0] disp_chars;
  logic [1:0]  tw_oe;
  logic        eeprom_sda = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [7:0]  m_led, m_gpo;
  logic [63:0] m_disp;
  logic [1:0]  m_twout, m_twoe;
  logic        m_twsel, m_err;

  always #4 clk = ~clk;

  board_regs_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .led_bar(led_bar), .disp_chars(disp_chars), .reset_req(reset_req), .gpo(gpo),
    .tw_scl(tw_scl), .tw_sda(tw_sda), .tw_oe(tw_oe), .tw_sel(tw_sel), .eeprom_sda(eeprom_sda)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] n);
    return (n <= 4'd9) ? 8'd48 + 8'(n) : 8'd55 + 8'(n);
  endfunction

  function automatic bit in_uart(input logic [19:0] o);
    return o >= 20'h900 && o <= 20'h9FF;
  endfunction

  function automatic int char_idx(input logic [19:0] o);
    for (int i = 0; i < 8; i++) if (o == 20'h418 + 20'(8*i)) return i;
    return -1;
  endfunction

  function automatic bit is_known(input logic [19:0] o);
    return in_uart(o) || char_idx(o) >= 0 || o == 20'h200 || o == 20'h408 || o == 20'h410 ||
           o == 20'h500 || o == 20'hA00 || o == 20'hB00 || o == 20'hB08 || o == 20'hB10 || o == 20'hB18;
  endfunction

  function automatic logic [31:0] exp_read(input logic [19:0] o, input logic sda);
    case (o)
      20'h408: return {24'h0, m_led};
      20'hA00: return {24'h0, m_gpo};
      20'hB00: return {30'h0, m_twout[1], sda};
      20'hB08: return {30'h0, m_twoe};
      20'hB10: return {30'h0, m_twout};
      20'hB18: return {31'h0, m_twsel};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [19:0] pick_off(input int k);
    case (k)
      0: return 20'h200;   1: return 20'h408;   2: return 20'h410;
      3: return 20'h418 + 20'(8 * ($urandom % 8));
      4: return 20'h500;   5: return 20'h900 + 20'($urandom % 256);
      6: return 20'hA00;   7: return 20'hB00;   8: return 20'hB08;
      9: return 20'hB10;   10: return 20'hB18;
      11: return 20'h41C;  12: return 20'h404;  13: return 20'hC00;
      default: return 20'h408;
    endcase
  endfunction

  task automatic model_reset();
    m_led = '0; m_gpo = '0; m_twout = '0; m_twoe = '0; m_twsel = 1'b0; m_err = 1'b0;
    m_disp = {8{8'h20}};
  endtask

  task automatic check_outputs(input string tag);
    check(led_bar == m_led, {tag, " R2 led"}, 64'(led_bar), 64'(m_led));
    check(gpo == m_gpo, {tag, " R10 gpo"}, 64'(gpo), 64'(m_gpo));
    check(disp_chars == m_disp, {tag, " R3/R4 display"}, disp_chars, m_disp);
    check({tw_scl, tw_sda, tw_oe, tw_sel} == {m_twout, m_twoe, m_twsel}, {tag, " R8 two-wire"},
          64'({tw_scl, tw_sda, tw_oe, tw_sel}), 64'({m_twout, m_twoe, m_twsel}));
    check(bus_err == m_err, {tag, " R13 err"}, 64'(bus_err), 64'(m_err));
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    logic [19:0] o;
    bit exp_pulse;
    int ci;
    o = a[19:0];
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    exp_pulse = (o == 20'h500) && (d == 32'h42);
    ci = char_idx(o);
    if (o == 20'h408) m_led = d[7:0];
    if (o == 20'hA00) m_gpo = d[7:0];
    if (o == 20'hB10) m_twout = d[1:0];
    if (o == 20'hB08) m_twoe = d[1:0];
    if (o == 20'hB18) m_twsel = d[0];
    if (o == 20'h410) for (int i = 0; i < 8; i++) m_disp[8*i +: 8] = hexch(d[31-4*i -: 4]);
    if (ci >= 0) m_disp[8*ci +: 8] = d[7:0];
    if (!is_known(o)) m_err = 1'b1;
    check(reset_req == exp_pulse, "R6 reset_req after write", 64'(reset_req), 64'(exp_pulse));
    check_outputs("write");
  endtask

  task automatic do_read(input logic [31:0] a);
    logic [19:0] o;
    logic s;
    bit exp_v;
    logic [31:0] exp_d;
    o = a[19:0];
    s = 1'($urandom);
    eeprom_sda = s;
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    exp_v = !in_uart(o);
    exp_d = exp_v ? exp_read(o, s) : 32'h0;
    if (!is_known(o)) m_err = 1'b1;
    check(bus_rvalid == exp_v, "R11/R12 rvalid", 64'(bus_rvalid), 64'(exp_v));
    check(bus_rdata == exp_d, "R9/R11/R13 rdata", 64'(bus_rdata), 64'(exp_d));
    check(bus_err == m_err, "R13 err after read", 64'(bus_err), 64'(m_err));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R5 reset state
    check(disp_chars == {8{8'h20}}, "R5 display spaces", disp_chars, {8{8'h20}});
    check({led_bar, gpo, tw_scl, tw_sda, tw_oe, tw_sel, bus_err, reset_req, bus_rvalid} == '0,
          "R5 outputs zero", 64'({led_bar, gpo, bus_err, reset_req, bus_rvalid}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 word expansion, MS nibble in char 0
    do_write(32'h0000_0410, 32'h0123_ABCF);
    check(disp_chars == {"FCBA3210"}, "R3 word hex", disp_chars, {"FCBA3210"});
    // R4 single character
    do_write(32'h0000_0450, 32'hFFFF_FF5A);
    check(disp_chars[63:56] == 8'h5A && disp_chars[55:0] == 56'h42_41_33_32_31_30 + (56'h43 << 48),
          "R4 char 7 only", disp_chars, {8'h5A, "CBA3210"});
    // R1 aliasing
    do_write(32'hFFF0_0408, 32'h0000_01A5);
    check(led_bar == 8'hA5, "R1 alias led", 64'(led_bar), 64'hA5);
    // R6 wrong key then key
    do_write(32'h0000_0500, 32'h0000_0043);
    do_write(32'h0000_0500, 32'h0000_0042);
    @(negedge clk);
    check(reset_req == 1'b0, "R6 single cycle", 64'(reset_req), 64'h0);
    // R7 switch
    do_write(32'h0000_0200, 32'hFFFF_FFFF);
    do_read(32'h0000_0200);
    // R12 uart window
    do_read(32'h0000_0940);
    do_write(32'h0000_09FC, 32'hDEAD_BEEF);
    // R9 input with both sda values
    do_write(32'h0000_0B10, 32'h2);
    do_read(32'h0000_0B00);
    do_read(32'h0000_0B00);
    // R11 write-only offsets read zero
    do_read(32'h0000_0410);
    do_read(32'h0000_0500);
    check(bus_err == 1'b0, "R11 no error on write-only reads", 64'(bus_err), 64'h0);
    // R13 unknown offset (misaligned char)
    do_read(32'h0000_041C);
    do_write(32'h0000_0408, 32'h11);

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [19:0] o;
      logic [31:0] a, d;
      o = pick_off(int'($urandom % 14));
      a = {12'($urandom), o};
      d = ($urandom % 4 == 0) ? 32'h42 : $urandom;
      if ($urandom % 2 == 0) do_write(a, d);
      else do_read(a);
    end

    // R13 / R5 error clears only by reset
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    check(bus_err == 1'b0, "R13 err cleared by reset", 64'(bus_err), 64'h0);
    check(disp_chars == {8{8'h20}}, "R5 spaces after reset", disp_chars, {8{8'h20}});
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule